// File: doc/BRIEF.md
# Predicate Condition Flag Generator

This block derives condition flags from a result predicate and a governing predicate that arrive as a stream of fixed-width words, least significant word first. A stream can be one word long or as long as a parameterised maximum. A start pulse opens a stream. Each word is presented with a valid strobe, and the final word is marked with a last flag. After the final word the block raises a one-cycle done strobe and holds four flags: negative, zero, carry and overflow.

Bits of the governing predicate select the active positions. The negative flag is the result bit at the lowest active position of the whole stream. The zero flag stays set only while no active position carries a result bit of one. The carry flag is the inverse of the result bit at the highest active position. A word with no active positions leaves every flag as it was. Because of this, the block keeps a sticky first-active marker and the running flags from one word to the next.

Top module: `pred_flag_gen`

## Requirements
- R1: While reset is applied and after it is released, `done` is 0 and the flags read N=0, Z=1, C=1, V=0.
- R2: When no governing bit is set in any word of a stream, the stream ends with N=0, Z=1, C=1.
- R3: N equals the result bit at the lowest set governing bit of the first word that has any governing bit set. Later words never change N.
- R4: Z is 0 exactly when at least one word of the stream has a nonzero bitwise AND of result and governing words. Once cleared, Z stays 0 until the next start.
- R5: C is the inverse of the result bit at the highest set governing bit of the last word that had any governing bit set. A word whose governing bits are all zero changes no flag.
- R6: V is 0 at all times.
- R7: `done` is 1 for one cycle only: the cycle after the clock edge that accepted the final word. The flags do not change after that until the next start.
- R8: A word presented while no stream is open and `start` is low is ignored. The flags stay unchanged and `done` stays 0.
- R9: A word presented in the same cycle as `start` is accepted as the first word of the new stream, on top of freshly cleared flags. A `start` without a word only clears the flags to the R2 values.
- R10: The word accepted in position MAX_WORDS ends the stream even when `lastWord` is low. Any further word is ignored under R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new stream and clears the flags |
| wordValid | input | 1 | A predicate word pair is presented this cycle |
| lastWord | input | 1 | The presented word is the final one of the stream |
| dWord | input | WORD_W | Result predicate word |
| gWord | input | WORD_W | Governing predicate word |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag, constant 0 |
| done | output | 1 | One-cycle strobe after the final word |

## Verification
Clearing the flags for a new stream and folding in the first word can happen in the same cycle when `start` and `wordValid` are both high. The merged case must see the cleared state, not the flags left by the previous stream. Table streams alternate between a merged start and a separate start cycle, with every new stream following one that ended with different flags. The flags and `done` are judged against a bit-serial reference walk of the same words.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

  // Running flag state; notZero is the inverted zero flag.
  typedef struct packed {
    logic neg;
    logic notZero;
    logic carry;
  } flagPack_t;

  localparam flagPack_t FLAGS_EMPTY = '{neg: 1'b0, notZero: 1'b0, carry: 1'b1};

  // Strobes from sequencing control to the flag datapath.
  typedef struct packed {
    logic clear;
    logic accept;
    logic finish;
  } ctlStrobe_t;

endpackage

// File: rtl/pflag_ctrl.sv
module pflag_ctrl
  import pflag_pkg::*;
#(
  parameter int MAX_WORDS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wordValid,
  input  logic       lastWord,
  output ctlStrobe_t strobe,
  output logic       done
);

  localparam int CNT_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS + 1) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(MAX_WORDS - 1);

  logic             busy;
  logic [CNT_W-1:0] wordCnt;
  logic [CNT_W-1:0] cntBase;

  always_comb begin
    cntBase       = start ? '0 : wordCnt;
    strobe.clear  = start;
    strobe.accept = wordValid & (busy | start);
    strobe.finish = strobe.accept & (lastWord | (cntBase == LAST_POS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wordCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.finish)     busy <= 1'b0;
      else if (strobe.clear) busy <= 1'b1;
      if (strobe.accept) wordCnt <= cntBase + 1'b1;
      else               wordCnt <= cntBase;
    end
  end

endmodule

// File: rtl/pflag_dpath.sv
module pflag_dpath
  import pflag_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [WORD_W-1:0] dWord,
  input  logic [WORD_W-1:0] gWord,
  output flagPack_t         flags
);

  flagPack_t         flagReg;
  flagPack_t         baseFlags;
  flagPack_t         nextFlags;
  logic              firstSeen;
  logic              baseSeen;
  logic              nextSeen;
  logic [WORD_W-1:0] lowBit;
  logic [WORD_W-1:0] highBit;
  logic              anyActive;
  logic              lowD;
  logic              highD;
  logic              hitD;

  // Lowest active position by two's complement isolation.
  assign lowBit    = gWord & (~gWord + 1'b1);
  assign anyActive = |gWord;

  // Highest active position by a top-down priority scan.
  always_comb begin
    logic seenAbove;
    seenAbove = 1'b0;
    highBit   = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      highBit[i] = gWord[i] & ~seenAbove;
      seenAbove  = seenAbove | gWord[i];
    end
  end

  assign lowD  = |(dWord & lowBit);
  assign highD = |(dWord & highBit);
  assign hitD  = |(dWord & gWord);

  always_comb begin
    baseFlags = strobe.clear ? FLAGS_EMPTY : flagReg;
    baseSeen  = strobe.clear ? 1'b0 : firstSeen;
    nextFlags = baseFlags;
    nextSeen  = baseSeen;
    if (strobe.accept && anyActive) begin
      if (!baseSeen) begin
        nextFlags.neg = lowD;
        nextSeen      = 1'b1;
      end
      nextFlags.notZero = baseFlags.notZero | hitD;
      nextFlags.carry   = ~highD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagReg   <= FLAGS_EMPTY;
      firstSeen <= 1'b0;
    end else begin
      flagReg   <= nextFlags;
      firstSeen <= nextSeen;
    end
  end

  assign flags = flagReg;

endmodule

// File: rtl/pred_flag_gen.sv
module pred_flag_gen
  import pflag_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int MAX_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wordValid,
  input  logic              lastWord,
  input  logic [WORD_W-1:0] dWord,
  input  logic [WORD_W-1:0] gWord,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV,
  output logic              done
);

  ctlStrobe_t strobe;
  flagPack_t  flags;

  pflag_ctrl #(.MAX_WORDS(MAX_WORDS)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wordValid (wordValid),
    .lastWord  (lastWord),
    .strobe    (strobe),
    .done      (done)
  );

  pflag_dpath #(.WORD_W(WORD_W)) i_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .dWord  (dWord),
    .gWord  (gWord),
    .flags  (flags)
  );

  assign flagN = flags.neg;
  assign flagZ = ~flags.notZero;
  assign flagC = flags.carry;
  assign flagV = 1'b0;

endmodule

// File: rtl/pflag_checker.sv
module pflag_checker #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wordValid,
  input logic [WORD_W-1:0] gWord,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagC,
  input logic              done
);

  // Inactive or idle cycles never move any flag.
  p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (!wordValid || (gWord == '0))) |=> $stable({flagN, flagZ, flagC}));

  // A cleared zero flag stays cleared within a stream.
  p_zero_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !flagZ) |=> !flagZ);

  // Once an active position was seen (Z cleared), N is frozen.
  p_neg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !flagZ) |=> $stable(flagN));

  // done only follows a cycle that presented a word.
  p_done_after_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wordValid));

  // A bare start restores the empty-stream flags.
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wordValid) |=> (flagZ && flagC && !flagN));

endmodule

bind pred_flag_gen pflag_checker #(.WORD_W(WORD_W)) i_pflag_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .wordValid (wordValid),
  .gWord     (gWord),
  .flagN     (flagN),
  .flagZ     (flagZ),
  .flagC     (flagC),
  .done      (done)
);

// File: tb/test_pred_flag_gen.sv
module test_pred_flag_gen;

  localparam int W  = 64;
  localparam int MW = 4;
  localparam int NV = 8;
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] TOP  = {1'b1, {(W-1){1'b0}}};

  // Table: word count, result words, governing words, expected {N,Z,C}
  localparam int           T_N [NV] = '{1, 1, 1, 2, 3, 4, 2, 4};
  localparam logic [W-1:0] T_D [NV][MW] = '{
    '{64'h1, 64'h0, 64'h0, 64'h0},
    '{64'h0, 64'h0, 64'h0, 64'h0},
    '{64'h10, 64'h0, 64'h0, 64'h0},
    '{ONES, ONES, 64'h0, 64'h0},
    '{64'h0, ONES, 64'h1, 64'h0},
    '{ONES, ONES, ONES, ONES},
    '{64'h1, 64'h0, 64'h0, 64'h0},
    '{ONES, ONES, ONES, 64'h10}};
  localparam logic [W-1:0] T_G [NV][MW] = '{
    '{64'h1, 64'h0, 64'h0, 64'h0},
    '{64'h0, 64'h0, 64'h0, 64'h0},
    '{64'hF0, 64'h0, 64'h0, 64'h0},
    '{64'h0, TOP, 64'h0, 64'h0},
    '{64'h2, 64'h0, 64'h1, 64'h0},
    '{64'h0, 64'h0, 64'h0, 64'h0},
    '{TOP | 64'h1, 64'h4, 64'h0, 64'h0},
    '{64'h0, 64'h0, 64'h0, 64'h10}};
  localparam logic [2:0]   T_EXP [NV] = '{3'b100, 3'b011, 3'b101, 3'b100,
                                          3'b000, 3'b011, 3'b101, 3'b100};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         wordValid = 1'b0;
  logic         lastWord = 1'b0;
  logic [W-1:0] dWord = '0;
  logic [W-1:0] gWord = '0;
  logic         flagN, flagZ, flagC, flagV, done;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] dv [MW];
  logic [W-1:0] gv [MW];

  always #5 clk = ~clk;

  pred_flag_gen #(.WORD_W(W), .MAX_WORDS(MW)) i_pred_flag_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .wordValid(wordValid),
    .lastWord(lastWord), .dWord(dWord), .gWord(gWord),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV), .done(done));

  task automatic checkEq(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Bit-serial reference over the stored stream.
  function automatic logic [2:0] refFlags(input int n);
    logic rn, rz, rc, seen;
    rn = 1'b0; rz = 1'b1; rc = 1'b1; seen = 1'b0;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < W; b++)
        if (gv[k][b]) begin
          if (!seen) begin rn = dv[k][b]; seen = 1'b1; end
          if (dv[k][b]) rz = 1'b0;
          rc = ~dv[k][b];
        end
    return {rn, rz, rc};
  endfunction

  task automatic runStream(input int n, input bit merged);
    @(negedge clk);
    start = 1'b1;
    if (merged) begin
      wordValid = 1'b1; dWord = dv[0]; gWord = gv[0]; lastWord = (n == 1);
    end
    @(negedge clk);
    start = 1'b0; wordValid = 1'b0; lastWord = 1'b0;
    for (int k = merged ? 1 : 0; k < n; k++) begin
      wordValid = 1'b1; dWord = dv[k]; gWord = gv[k]; lastWord = (k == n - 1);
      @(negedge clk);
    end
    wordValid = 1'b0; lastWord = 1'b0;
  endtask

  task automatic judge(input string req, input logic [2:0] exp);
    checkEq({req, " done"}, {7'd0, done}, 8'd1);
    checkEq({req, " flags"}, {4'd0, flagV, flagN, flagZ, flagC}, {5'd0, exp});
    @(negedge clk);
    checkEq("R7 done one cycle", {7'd0, done}, 8'd0);
    checkEq("R7 flags held", {5'd0, flagN, flagZ, flagC}, {5'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R1 reset held", {4'd0, done, flagN, flagZ, flagC}, 8'b0000_0011);
    rst_n = 1'b1;
    @(negedge clk);
    checkEq("R1 reset state", {3'd0, flagV, done, flagN, flagZ, flagC}, 8'b0000_0011);

    // Table walk, alternating merged start (R9) and separate start.
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < MW; k++) begin dv[k] = T_D[v][k]; gv[k] = T_G[v][k]; end
      runStream(T_N[v], v[0]);
      judge("R2 R3 R4 R5 R6 R9 table", T_EXP[v]);
    end

    // R8: word while idle, flags currently 100 from last entry.
    @(negedge clk);
    wordValid = 1'b1; lastWord = 1'b1; dWord = '0; gWord = 64'h1;
    @(negedge clk);
    wordValid = 1'b0; lastWord = 1'b0;
    checkEq("R8 idle word ignored", {4'd0, done, flagN, flagZ, flagC}, 8'b0000_0100);

    // R10: four words without lastWord, then a fifth that must be ignored.
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < MW; k++) begin
      wordValid = 1'b1; lastWord = 1'b0;
      gWord = (k == 0 || k == MW - 1) ? 64'h1 : 64'h0;
      dWord = (k == MW - 1) ? 64'h1 : 64'h0;
      @(negedge clk);
    end
    checkEq("R10 forced end done", {7'd0, done}, 8'd1);
    checkEq("R10 forced end flags", {5'd0, flagN, flagZ, flagC}, 8'b0000_0000);
    gWord = 64'h1; dWord = 64'h0;
    @(negedge clk);
    wordValid = 1'b0;
    checkEq("R10 R8 extra word ignored", {4'd0, done, flagN, flagZ, flagC}, 8'b0000_0000);

    // Random streams against the bit-serial reference.
    for (int r = 0; r < 40; r++) begin
      int n;
      n = 1 + int'($urandom_range(0, MW - 1));
      for (int k = 0; k < MW; k++) begin
        dv[k] = {$urandom, $urandom};
        case ($urandom_range(0, 3))
          0: gv[k] = '0;
          1: gv[k] = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
          2: gv[k] = W'(1) << $urandom_range(0, W - 1);
          default: gv[k] = {$urandom, $urandom};
        endcase
      end
      runStream(n, r[0]);
      judge("R3 R4 R5 random", refFlags(n));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule